// File: doc/BRIEF.md
# Indexed Batch Packet Buffer

This block gathers variable-length packets, arriving as a byte stream with start and end markers, into a single buffer memory. Each packet is placed directly after the one before it, with no padding. A small table of start addresses sits at the low addresses of the same memory. Table slot k holds the buffer address of the first byte of packet k. A reader therefore gets the whole batch, table and payload, as one contiguous region. To locate packet k, it reads slot k and then reads from that address. Each reader uses only its own index, so no locking between readers is needed.

A batch is never handed over packet by packet. It is sealed only in one of these cases:
- the table has used all its slots;
- the payload area is exactly full;
- the next packet announced would not fit in the remaining payload space. That packet is then held back and becomes packet 0 of the following batch.

Two buffers alternate, so collection continues in one while the other waits for the reader. The reader signals that it is done with a one-cycle release pulse.

Input packets carry their byte count on the start byte. The count must be between 1 and `PAYLOAD_BYTES` and must agree with the end marker. The total depth `DIR_ENTRIES + PAYLOAD_BYTES` must fit in `DATA_W` bits.

Top module: `pktbatch_buf`

## Requirements
- R1: After reset, `in_ready` is 1, `batch_ready` is 0 and `batch_count` is 0.
- R2: Packets are stored back to back. In every batch, packet 0 starts at address `DIR_ENTRIES`, and packet k+1 starts at the start address of packet k plus the length of packet k. Byte i of a packet sits at its start address plus i.
- R3: Table slot k (buffer address k, for k < `batch_count`) holds the start address of packet k, as an unsigned `DATA_W`-bit value.
- R4: When the end byte of the `DIR_ENTRIES`-th packet of a batch is accepted, `batch_ready` is 1 in the following cycle, with `batch_count` equal to `DIR_ENTRIES`.
- R5: When an accepted end byte brings the payload to exactly `PAYLOAD_BYTES` bytes, the batch is sealed in the following cycle with the packets received so far. No byte is ever written outside the payload area.
- R6: Suppose a start byte is offered whose `in_len` exceeds the free payload space, and the current batch holds at least one packet. Then `in_ready` is 0 in that cycle, and the current batch is sealed without that packet. The packet is then stored as packet 0 of the next batch, at address `DIR_ENTRIES`.
- R7: While neither limit has been reached, `batch_ready` stays 0. No empty batch is ever sealed.
- R8: While one sealed batch waits for the reader, the writer keeps accepting packets into the other buffer. When both buffers hold sealed batches, `in_ready` is 0.
- R9: A `batch_release` pulse while `batch_ready` is 1 frees the presented buffer. Batches are presented in the order they were sealed. A second sealed batch is presented in the cycle after the release.
- R10: A read with `rd_en` at address a of the presented batch returns that word on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_len | input | LEN_W | Packet byte count, read on the first byte |
| in_data | input | DATA_W | Input byte |
| batch_ready | output | 1 | A sealed batch is presented to the reader |
| batch_count | output | CNT_W | Number of packets in the presented batch |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address in the presented batch |
| rd_data | output | DATA_W | Read data, one cycle after rd_en |
| batch_release | input | 1 | Reader is finished with the presented batch |

## Verification
A wrong fill pointer shows up as soon as the first batch is read back. The table slot or the first byte of the following packet sits at the wrong address. A lost or doubled packet count shows as a `batch_count` mismatch in the cycle after sealing. A seal decision that is off shows within one cycle of the triggering end byte or start byte, because `batch_ready` either rises early, rises late, or `in_ready` fails to drop. Bank selection faults show only when a second batch is collected while the first is still held. Such faults appear at the reader as a batch out of order or as `in_ready` staying high with both buffers full.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  // Free payload bytes left when the next write goes to address wptr.
  function automatic int room_left(input int wptr, input int depth);
    return depth - wptr;
  endfunction

  // A packet of len bytes may start only if it fits in the free space.
  function automatic logic pkt_fits(input int len, input int wptr, input int depth);
    return len <= room_left(wptr, depth);
  endfunction

  // After an end byte: seal when the table or the payload area is exhausted.
  function automatic logic must_seal(input int cnt_next, input int entries,
                                     input int wptr_next, input int depth);
    return (cnt_next >= entries) || (wptr_next >= depth);
  endfunction
endpackage

// File: rtl/ipb_fill_ctl.sv
module ipb_fill_ctl #(
  parameter int DATA_W      = 8,
  parameter int DIR_ENTRIES = 4,
  parameter int DEPTH       = 28,
  parameter int ADDR_W      = 5,
  parameter int PTR_W       = 5,
  parameter int CNT_W       = 3,
  parameter int LEN_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              bank_free,
  output logic              in_ready,
  output logic              accept,
  output logic              seal,
  output logic [CNT_W-1:0]  seal_cnt,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [PTR_W-1:0]  fill_ptr,
  output logic              dir_we,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [DATA_W-1:0] dir_data,
  output logic              dat_we,
  output logic [ADDR_W-1:0] dat_addr
);
  import ipb_pkg::*;

  logic [PTR_W-1:0] wptr, wptr_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             hold, seal_hold, seal_end;

  // A start byte that cannot fit a non-empty batch forces the seal.
  assign hold      = in_valid && in_sop && (cnt != '0) &&
                     !pkt_fits(int'(in_len), int'(wptr), DEPTH);
  assign seal_hold = hold && bank_free;
  assign in_ready  = bank_free && !hold;
  assign accept    = in_valid && in_ready;

  assign cnt_nxt  = cnt + CNT_W'(accept && in_sop);
  assign wptr_nxt = wptr + PTR_W'(accept);
  assign seal_end = accept && in_eop &&
                    must_seal(int'(cnt_nxt), DIR_ENTRIES, int'(wptr_nxt), DEPTH);
  assign seal     = seal_hold || seal_end;
  assign seal_cnt = seal_hold ? cnt : cnt_nxt;

  // The table slot is written together with the first payload byte.
  assign dir_we   = accept && in_sop;
  assign dir_addr = ADDR_W'(cnt);
  assign dir_data = DATA_W'(wptr);
  assign dat_we   = accept;
  assign dat_addr = ADDR_W'(wptr);

  assign fill_cnt = cnt;
  assign fill_ptr = wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= PTR_W'(DIR_ENTRIES);
      cnt  <= '0;
    end else if (seal) begin
      wptr <= PTR_W'(DIR_ENTRIES);
      cnt  <= '0;
    end else begin
      wptr <= wptr_nxt;
      cnt  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ipb_bank_ctl.sv
module ipb_bank_ctl #(
  parameter int CNT_W  = 3,
  parameter int NBANKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seal,
  input  logic [CNT_W-1:0] seal_cnt,
  input  logic             batch_release,
  output logic             wr_bank,
  output logic             rd_bank,
  output logic [NBANKS-1:0] bank_full,
  output logic             bank_free,
  output logic             batch_ready,
  output logic [CNT_W-1:0] batch_count
);
  logic             rel_ok;
  logic [CNT_W-1:0] bank_cnt [NBANKS];

  assign batch_ready = bank_full[rd_bank];
  assign batch_count = batch_ready ? bank_cnt[rd_bank] : '0;
  assign bank_free   = !bank_full[wr_bank];
  assign rel_ok      = batch_release && batch_ready;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic             full_q;
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (seal && (wr_bank == 1'(g))) begin
          full_q <= 1'b1;
          cnt_q  <= seal_cnt;
        end else if (rel_ok && (rd_bank == 1'(g))) begin
          full_q <= 1'b0;
        end
      end
    end
    assign bank_full[g] = full_q;
    assign bank_cnt[g]  = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
    end else begin
      if (seal)   wr_bank <= ~wr_bank;
      if (rel_ok) rd_bank <= ~rd_bank;
    end
  end
endmodule

// File: rtl/ipb_store.sv
module ipb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 28,
  parameter int ADDR_W = 5,
  parameter int NBANKS = 2
) (
  input  logic              clk,
  input  logic              wr_bank,
  input  logic              dir_we,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] dir_data,
  input  logic              dat_we,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              rd_bank,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank_rd [NBANKS];

  for (genvar g = 0; g < NBANKS; g++) begin : g_mem
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_bank == 1'(g)) begin
        if (dir_we) mem[dir_addr] <= dir_data;
        if (dat_we) mem[dat_addr] <= dat_data;
      end
    end
    assign bank_rd[g] = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= bank_rd[rd_bank];
  end
endmodule

// File: rtl/pktbatch_buf.sv
module pktbatch_buf #(
  parameter int DATA_W        = 8,
  parameter int DIR_ENTRIES   = 4,
  parameter int PAYLOAD_BYTES = 24,
  localparam int DEPTH  = DIR_ENTRIES + PAYLOAD_BYTES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(DIR_ENTRIES + 1),
  localparam int LEN_W  = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  output logic              batch_ready,
  output logic [CNT_W-1:0]  batch_count,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              batch_release
);
  localparam int NBANKS = 2;

  // Named internal events, observed by the bound checker.
  logic              accept, seal, bank_free, wr_bank, rd_bank;
  logic [NBANKS-1:0] bank_full;
  logic [CNT_W-1:0]  seal_cnt, fill_cnt;
  logic [PTR_W-1:0]  fill_ptr;
  logic              dir_we, dat_we;
  logic [ADDR_W-1:0] dir_addr, dat_addr;
  logic [DATA_W-1:0] dir_data;

  ipb_fill_ctl #(
    .DATA_W(DATA_W), .DIR_ENTRIES(DIR_ENTRIES), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) fill_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_len(in_len), .bank_free(bank_free),
    .in_ready(in_ready), .accept(accept), .seal(seal), .seal_cnt(seal_cnt),
    .fill_cnt(fill_cnt), .fill_ptr(fill_ptr), .dir_we(dir_we),
    .dir_addr(dir_addr), .dir_data(dir_data), .dat_we(dat_we),
    .dat_addr(dat_addr)
  );

  ipb_bank_ctl #(.CNT_W(CNT_W), .NBANKS(NBANKS)) bank_i (
    .clk(clk), .rst_n(rst_n), .seal(seal), .seal_cnt(seal_cnt),
    .batch_release(batch_release), .wr_bank(wr_bank), .rd_bank(rd_bank),
    .bank_full(bank_full), .bank_free(bank_free),
    .batch_ready(batch_ready), .batch_count(batch_count)
  );

  ipb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NBANKS(NBANKS)) store_i (
    .clk(clk), .wr_bank(wr_bank), .dir_we(dir_we), .dir_addr(dir_addr),
    .dir_data(dir_data), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_data(in_data), .rd_bank(rd_bank), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/ipb_checker.sv
module ipb_checker #(
  parameter int DIR_ENTRIES = 4,
  parameter int DEPTH       = 28,
  parameter int ADDR_W      = 5,
  parameter int PTR_W       = 5,
  parameter int CNT_W       = 3,
  parameter int LEN_W       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sop,
  input logic [LEN_W-1:0]  in_len,
  input logic              batch_ready,
  input logic              batch_release,
  input logic              seal,
  input logic [CNT_W-1:0]  seal_cnt,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic [PTR_W-1:0]  fill_ptr,
  input logic              dat_we,
  input logic [ADDR_W-1:0] dat_addr,
  input logic              wr_bank,
  input logic              rd_bank,
  input logic [1:0]        bank_full
);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |-> (int'(dat_addr) >= DIR_ENTRIES) && (int'(dat_addr) < DEPTH));

  assert_entry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_cnt) <= DIR_ENTRIES);

  assert_start_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop) |-> (int'(in_len) <= DEPTH - int'(fill_ptr)));

  assert_seal_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> (seal_cnt != '0));

  assert_both_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_full == 2'b11) |-> !in_ready);

  assert_seal_swaps_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seal |=> (wr_bank != $past(wr_bank)));

  assert_release_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_release && batch_ready) |=> (rd_bank != $past(rd_bank)));
endmodule

bind pktbatch_buf ipb_checker #(
  .DIR_ENTRIES(DIR_ENTRIES), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
  .PTR_W(PTR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .in_len(in_len), .batch_ready(batch_ready),
  .batch_release(batch_release), .seal(seal), .seal_cnt(seal_cnt),
  .fill_cnt(fill_cnt), .fill_ptr(fill_ptr), .dat_we(dat_we),
  .dat_addr(dat_addr), .wr_bank(wr_bank), .rd_bank(rd_bank),
  .bank_full(bank_full)
);

// File: tb/pktbatch_buf_tb_top.sv
`timescale 1ns/1ps
module pktbatch_buf_tb_top;
  localparam int DATA_W = 8;
  localparam int DIRN   = 4;
  localparam int PAY    = 24;
  localparam int DEPTH  = DIRN + PAY;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DIRN + 1);
  localparam int LEN_W  = $clog2(PAY + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, rd_en = 0, batch_release = 0;
  logic [LEN_W-1:0]  in_len = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic in_ready, batch_ready;
  logic [CNT_W-1:0]  batch_count;
  logic [DATA_W-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_len[$];
  int exp_byte[$];

  always #2 clk = ~clk;

  pktbatch_buf #(.DATA_W(DATA_W), .DIR_ENTRIES(DIRN), .PAYLOAD_BYTES(PAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_len(in_len), .in_data(in_data),
    .batch_ready(batch_ready), .batch_count(batch_count), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .batch_release(batch_release)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: sends one packet and records it in the scoreboard.
  task automatic send_pkt(input int len, input int seed);
    exp_len.push_back(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_len = LEN_W'(len); in_data = DATA_W'(seed + i);
      exp_byte.push_back((seed + i) & 8'hff);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic read_word(input int a, output int v);
    @(negedge clk);
    rd_en = 1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = int'(rd_data);
    rd_en = 0;
  endtask

  // Monitor: reads the presented batch and compares with the scoreboard.
  task automatic drain(input int n);
    int base, v, len;
    chk("R9 batch presented", int'(batch_ready), 1);
    chk("R4/R5 batch_count", int'(batch_count), n);
    base = DIRN;
    for (int k = 0; k < n; k++) begin
      read_word(k, v);
      len = exp_len.pop_front();
      chk("R3 table slot", v, base);
      for (int i = 0; i < len; i++) begin
        read_word(base + i, v);
        chk("R2 R10 payload byte", v, exp_byte.pop_front());
      end
      base += len;
    end
    @(negedge clk); batch_release = 1;
    @(negedge clk); batch_release = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 batch_ready", int'(batch_ready), 0);
    chk("R1 batch_count", int'(batch_count), 0);

    // Table limit triggers the hand-off.
    send_pkt(2, 8'h10); send_pkt(3, 8'h20); send_pkt(1, 8'h30);
    chk("R7 no early hand-off", int'(batch_ready), 0);
    send_pkt(4, 8'h40);
    chk("R4 sealed on last slot", int'(batch_ready), 1);
    drain(4);
    chk("R9 released", int'(batch_ready), 0);

    // Exact payload fill triggers the hand-off.
    send_pkt(10, 8'h50);
    chk("R7 no early hand-off", int'(batch_ready), 0);
    send_pkt(14, 8'h70);
    chk("R5 sealed on full payload", int'(batch_ready), 1);
    drain(2);

    // Oversized start byte is held back for the next batch.
    send_pkt(10, 8'h90); send_pkt(10, 8'hA0);
    chk("R7 four bytes free, not sealed", int'(batch_ready), 0);
    @(negedge clk);
    in_valid = 1; in_sop = 1; in_eop = 0; in_len = LEN_W'(6); in_data = 8'hB0;
    #1;
    chk("R6 in_ready low on hold", int'(in_ready), 0);
    send_pkt(6, 8'hB0);
    chk("R6 prior batch sealed", int'(batch_ready), 1);
    drain(2);
    send_pkt(1, 8'hC0); send_pkt(1, 8'hC1); send_pkt(1, 8'hC2);
    drain(4);

    // Ping-pong: second batch collected while first is held.
    for (int p = 0; p < 4; p++) send_pkt(1, 8'hD0 + p);
    chk("R8 first batch sealed", int'(batch_ready), 1);
    chk("R8 writer still ready", int'(in_ready), 1);
    for (int p = 0; p < 4; p++) send_pkt(2, 8'hE0 + 2 * p);
    chk("R8 both full blocks input", int'(in_ready), 0);
    drain(4);
    chk("R9 next batch presented", int'(batch_ready), 1);
    chk("R8 input reopened", int'(in_ready), 1);
    drain(4);
    chk("R9 all released", int'(batch_ready), 0);
    chk("R2 scoreboard empty", exp_byte.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule